// File: doc/BRIEF.md
# Bus-Attached 16x16 Multiply-Accumulate Unit

This peripheral sits on a word-wide synchronous register bus and multiplies two 16-bit operands, treating them as either unsigned or two's complement, with the option of adding each product into a 32-bit running accumulator. Software picks the arithmetic mode by choosing which of four first-operand addresses it writes. The write of the second operand performs the computation in that same clock edge. The 32-bit result is read back as a low word, a high word and a third word that holds sign or carry information.

Software can also preset the result and the accumulator by writing the low result word. The value is widened according to the signedness of the current mode. This allows a multiply-accumulate chain to start from a chosen value.

Top module: `mmio_mac16`

## Requirements
- R1: After reset the result, the accumulator and the carry flag are zero and the mode is unsigned multiply, so all three result words read 0x0000.
- R2: A write to BASE+0x0, BASE+0x2, BASE+0x4 or BASE+0x6 (BASE defaults to 0x130) stores the written word as operand 1 and selects, in that order, unsigned multiply, signed multiply, unsigned accumulate or signed accumulate.
- R3: A write to BASE+0x8 uses the written word as operand 2. In the two plain modes, the 32-bit product replaces the result and clears the accumulator. The signed mode treats both operands as two's complement.
- R4: In the two accumulate modes, a write to BASE+0x8 adds the product to the accumulator modulo 2^32, and the result then equals the new accumulator. The signed variant sign-extends both operands before multiplying.
- R5: A read at BASE+0xA returns result bits 15:0 and a read at BASE+0xC returns bits 31:16. A read at any other address except BASE+0xE returns zero, and the read data is zero whenever the read enable is low.
- R6: A read at BASE+0xE returns the extension word. It is 0x0000 in unsigned multiply mode and 0x0000 or 0x0001 (the carry out of bit 31 from the latest unsigned accumulate) in unsigned accumulate mode. In both signed modes it is 0xFFFF when result bit 31 is set and 0x0000 otherwise.
- R7: A write to BASE+0xA loads both the result and the accumulator with the written word and clears the carry flag. The word is zero-extended in unsigned modes and sign-extended in signed modes.
- R8: Writes to BASE+0xC, BASE+0xE and any address outside the eight-word window change neither the operands, the mode, the result nor the accumulator.
- R9: A result read in the cycle after an operand-2 or low-result write returns the new value. A read of the low word in the same cycle as a write to it returns the previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W | Byte address of the word access |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 16 | Write data |
| bus_re | input | 1 | Read enable |
| bus_rdata | output | 16 | Read data, combinational from registered state |

## Verification
The low result word is both a read location and a load location, so a read and a preset of that word can fall in the same cycle. The bench drives both enables together at BASE+0xA and expects the value held before the edge. On the next cycle it expects the widened preset value. A reference model updated at each rising edge and compared on every cycle also judges operand-2 writes that are immediately followed by reads across random traffic in all four modes.

// File: rtl/mac16_pkg.sv
package mac16_pkg;
    localparam int WORD_W   = 16;
    localparam int PROD_W   = 2 * WORD_W;
    localparam int NUM_REGS = 8;
    localparam int STEP     = WORD_W / 8;

    // Register slots in the window; slot k sits at BASE + STEP*k.
    localparam int SLOT_OP2 = 4;
    localparam int SLOT_RLO = 5;
    localparam int SLOT_RHI = 6;
    localparam int SLOT_EXT = 7;

    // Bit 0 = signed, bit 1 = accumulate; slot index 0..3 maps straight onto it.
    typedef enum logic [1:0] {
        MODE_UMUL = 2'b00,
        MODE_SMUL = 2'b01,
        MODE_UMAC = 2'b10,
        MODE_SMAC = 2'b11
    } mac_mode_e;

    typedef struct packed {
        logic [PROD_W-1:0] res;
        logic [PROD_W-1:0] acc;
        logic              carry;
    } mac_state_t;

    function automatic logic mode_signed(mac_mode_e m);
        return m[0];
    endfunction

    function automatic logic mode_accum(mac_mode_e m);
        return m[1];
    endfunction

    function automatic logic [PROD_W-1:0] widen(logic [WORD_W-1:0] v, logic sgn);
        return sgn ? {{WORD_W{v[WORD_W-1]}}, v} : {{WORD_W{1'b0}}, v};
    endfunction
endpackage

// File: rtl/mac16_decode.sv
module mac16_decode
    import mac16_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int BASE_ADDR = 'h130
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic [NUM_REGS-1:0] hit
);
    for (genvar k = 0; k < NUM_REGS; k++) begin : g_slot
        localparam logic [ADDR_W-1:0] SLOT_ADDR = ADDR_W'(BASE_ADDR + STEP * k);
        assign hit[k] = (addr == SLOT_ADDR);
    end
endmodule

// File: rtl/mac16_mult.sv
module mac16_mult
    import mac16_pkg::*;
(
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    input  logic              sgn,
    output logic [PROD_W-1:0] prod
);
    logic [PROD_W-1:0] wa, wb;

    // Widening both operands to the product width makes the truncated
    // unsigned product correct for two's complement as well.
    assign wa   = widen(a, sgn);
    assign wb   = widen(b, sgn);
    assign prod = wa * wb;
endmodule

// File: rtl/mac16_next.sv
module mac16_next
    import mac16_pkg::*;
(
    input  mac_state_t        cur,
    input  mac_mode_e         mode,
    input  logic              op2_wr,
    input  logic              lo_wr,
    input  logic [PROD_W-1:0] prod,
    input  logic [WORD_W-1:0] wdata,
    output mac_state_t        nxt
);
    logic [PROD_W:0] sum;

    assign sum = {1'b0, cur.acc} + {1'b0, prod};

    always_comb begin
        nxt = cur;
        if (op2_wr) begin
            if (mode_accum(mode)) begin
                nxt.acc   = sum[PROD_W-1:0];
                nxt.res   = sum[PROD_W-1:0];
                nxt.carry = ~mode_signed(mode) & sum[PROD_W];
            end else begin
                nxt.res   = prod;
                nxt.acc   = '0;
                nxt.carry = 1'b0;
            end
        end else if (lo_wr) begin
            nxt.res   = widen(wdata, mode_signed(mode));
            nxt.acc   = widen(wdata, mode_signed(mode));
            nxt.carry = 1'b0;
        end
    end
endmodule

// File: rtl/mac16_readmux.sv
module mac16_readmux
    import mac16_pkg::*;
(
    input  logic                re,
    input  logic [NUM_REGS-1:0] hit,
    input  mac_state_t          st,
    input  mac_mode_e           mode,
    output logic [WORD_W-1:0]   rdata
);
    logic [WORD_W-1:0] ext;

    always_comb begin
        unique case (mode)
            MODE_UMUL: ext = '0;
            MODE_UMAC: ext = {{(WORD_W-1){1'b0}}, st.carry};
            default:   ext = {WORD_W{st.res[PROD_W-1]}};
        endcase
    end

    always_comb begin
        rdata = '0;
        if (re) begin
            if (hit[SLOT_RLO]) rdata = st.res[WORD_W-1:0];
            if (hit[SLOT_RHI]) rdata = st.res[PROD_W-1:WORD_W];
            if (hit[SLOT_EXT]) rdata = ext;
        end
    end
endmodule

// File: rtl/mmio_mac16.sv
module mmio_mac16
    import mac16_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int BASE_ADDR = 'h130
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [WORD_W-1:0] bus_wdata,
    input  logic              bus_re,
    output logic [WORD_W-1:0] bus_rdata
);
    logic [NUM_REGS-1:0] hit;
    logic [WORD_W-1:0]   op1_q;
    mac_mode_e           mode_q;
    logic [PROD_W-1:0]   res_q, acc_q;
    logic                carry_q;
    mac_state_t          cur, nxt;
    logic [PROD_W-1:0]   prod;
    logic                op1_wr;
    mac_mode_e           mode_sel;

    mac16_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
        .addr (bus_addr),
        .hit  (hit)
    );

    // First four slots load operand 1; the slot index is the mode code.
    always_comb begin
        op1_wr   = 1'b0;
        mode_sel = mode_q;
        for (int k = 0; k < 4; k++) begin
            if (bus_we && hit[k]) begin
                op1_wr   = 1'b1;
                mode_sel = mac_mode_e'(k[1:0]);
            end
        end
    end

    mac16_mult u_mult (
        .a    (op1_q),
        .b    (bus_wdata),
        .sgn  (mode_signed(mode_q)),
        .prod (prod)
    );

    assign cur = '{res: res_q, acc: acc_q, carry: carry_q};

    mac16_next u_next (
        .cur    (cur),
        .mode   (mode_q),
        .op2_wr (bus_we && hit[SLOT_OP2]),
        .lo_wr  (bus_we && hit[SLOT_RLO]),
        .prod   (prod),
        .wdata  (bus_wdata),
        .nxt    (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            op1_q   <= '0;
            mode_q  <= MODE_UMUL;
            res_q   <= '0;
            acc_q   <= '0;
            carry_q <= 1'b0;
        end else begin
            if (op1_wr) begin
                op1_q  <= bus_wdata;
                mode_q <= mode_sel;
            end
            res_q   <= nxt.res;
            acc_q   <= nxt.acc;
            carry_q <= nxt.carry;
        end
    end

    mac16_readmux u_rd (
        .re    (bus_re),
        .hit   (hit),
        .st    (cur),
        .mode  (mode_q),
        .rdata (bus_rdata)
    );
endmodule

// File: rtl/mac16_chk.sv
module mac16_chk
    import mac16_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int BASE_ADDR = 'h130
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [WORD_W-1:0] bus_wdata,
    input logic              bus_re,
    input logic [WORD_W-1:0] bus_rdata,
    input mac_mode_e         mode_q,
    input logic [PROD_W-1:0] res_q,
    input logic [PROD_W-1:0] acc_q,
    input logic              carry_q
);
    localparam logic [ADDR_W-1:0] A_OP2 = ADDR_W'(BASE_ADDR + STEP * SLOT_OP2);
    localparam logic [ADDR_W-1:0] A_RLO = ADDR_W'(BASE_ADDR + STEP * SLOT_RLO);
    localparam logic [ADDR_W-1:0] A_RHI = ADDR_W'(BASE_ADDR + STEP * SLOT_RHI);
    localparam logic [ADDR_W-1:0] A_EXT = ADDR_W'(BASE_ADDR + STEP * SLOT_EXT);

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (res_q == '0 && acc_q == '0 && !carry_q && mode_q == MODE_UMUL));

    assert_plain_clears_acc_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == A_OP2 && !mode_accum(mode_q)) |=> acc_q == '0);

    assert_mac_mirror_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == A_OP2 && mode_accum(mode_q)) |=> res_q == acc_q);

    assert_idle_read_R5: assert property (@(posedge clk) disable iff (rst)
        !bus_re |-> bus_rdata == '0);

    assert_ext_umul_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_re && bus_addr == A_EXT && mode_q == MODE_UMUL) |-> bus_rdata == '0);

    assert_ext_smul_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_re && bus_addr == A_EXT && mode_q == MODE_SMUL)
            |-> bus_rdata == {WORD_W{res_q[PROD_W-1]}});

    assert_low_load_signed_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == A_RLO && mode_signed(mode_q))
            |=> res_q[PROD_W-1:WORD_W] == {WORD_W{$past(bus_wdata[WORD_W-1])}});

    assert_readonly_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_we && (bus_addr == A_RHI || bus_addr == A_EXT))
            |=> ($stable(res_q) && $stable(acc_q) && $stable(mode_q)));
endmodule

bind mmio_mac16 mac16_chk #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_re    (bus_re),
    .bus_rdata (bus_rdata),
    .mode_q    (mode_q),
    .res_q     (res_q),
    .acc_q     (acc_q),
    .carry_q   (carry_q)
);

// File: tb/tb_mmio_mac16.sv
`timescale 1ns/1ps
module tb_mmio_mac16;
    localparam logic [15:0] A_UMUL = 16'h130, A_SMUL = 16'h132, A_UMAC = 16'h134,
                            A_SMAC = 16'h136, A_OP2  = 16'h138, A_RLO  = 16'h13A,
                            A_RHI  = 16'h13C, A_EXT  = 16'h13E;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic        bus_re = 1'b0;
    logic [15:0] bus_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    logic [15:0] last_rd;

    // Reference model state
    logic [15:0] m_op1;
    logic [1:0]  m_mode;
    logic [31:0] m_res, m_acc;
    logic        m_carry;

    always #10 clk = ~clk;

    mmio_mac16 dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata)
    );

    task automatic check(input logic [15:0] got, input logic [15:0] exp, input string tag);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_op1 = '0; m_mode = 2'd0; m_res = '0; m_acc = '0; m_carry = 1'b0;
    endtask

    function automatic logic [15:0] model_read(input logic [15:0] a, input logic r);
        if (!r) return 16'h0;
        case (a)
            A_RLO: return m_res[15:0];
            A_RHI: return m_res[31:16];
            A_EXT: case (m_mode)
                2'd0:    return 16'h0;
                2'd2:    return {15'h0, m_carry};
                default: return {16{m_res[31]}};
            endcase
            default: return 16'h0;
        endcase
    endfunction

    task automatic model_update(input logic [15:0] a, input logic w, input logic [15:0] d);
        longint pa, s;
        if (!w) return;
        case (a)
            A_UMUL, A_SMUL, A_UMAC, A_SMAC: begin
                m_op1  = d;
                m_mode = 2'((a - A_UMUL) >> 1);
            end
            A_OP2: begin
                if (m_mode[0]) pa = longint'($signed(m_op1)) * longint'($signed(d));
                else           pa = longint'(m_op1) * longint'(d);
                if (m_mode[1]) begin
                    s       = longint'(m_acc) + (pa & 64'hFFFF_FFFF);
                    m_carry = !m_mode[0] && s[32];
                    m_acc   = s[31:0];
                    m_res   = m_acc;
                end else begin
                    m_res = pa[31:0]; m_acc = '0; m_carry = 1'b0;
                end
            end
            A_RLO: begin
                m_res   = m_mode[0] ? {{16{d[15]}}, d} : {16'h0, d};
                m_acc   = m_res;
                m_carry = 1'b0;
            end
            default: ;
        endcase
    endtask

    // One bus cycle: drive at falling edge, compare against the model, advance at rising edge.
    task automatic cyc(input logic [15:0] a, input logic w, input logic [15:0] d,
                       input logic r, input string tag);
        @(negedge clk);
        bus_addr = a; bus_we = w; bus_wdata = d; bus_re = r;
        #1;
        last_rd = bus_rdata;
        check(bus_rdata, model_read(a, r), tag);
        @(posedge clk);
        model_update(a, w, d);
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d, input string tag);
        cyc(a, 1'b1, d, 1'b0, tag);
    endtask

    task automatic rd_exp(input logic [15:0] a, input logic [15:0] exp, input string tag);
        cyc(a, 1'b0, 16'h0, 1'b1, tag);
        check(last_rd, exp, tag);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        logic [15:0] ra, rd;
        logic rw, rr;
        void'($urandom(32'd7));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1: reset state
        rd_exp(A_RLO, 16'h0000, "R1 low after reset");
        rd_exp(A_RHI, 16'h0000, "R1 high after reset");
        rd_exp(A_EXT, 16'h0000, "R1 ext after reset");

        // R2, R3: unsigned multiply of max operands
        wr(A_UMUL, 16'hFFFF, "R2 op1 umul");
        wr(A_OP2,  16'hFFFF, "R3 op2 umul");
        rd_exp(A_RLO, 16'h0001, "R3 umul low");
        rd_exp(A_RHI, 16'hFFFE, "R3 umul high");
        rd_exp(A_EXT, 16'h0000, "R6 umul ext");

        // R3, R6: signed multiply -1 * 2
        wr(A_SMUL, 16'hFFFF, "R2 op1 smul");
        wr(A_OP2,  16'h0002, "R3 op2 smul");
        rd_exp(A_RLO, 16'hFFFE, "R3 smul low");
        rd_exp(A_RHI, 16'hFFFF, "R3 smul high");
        rd_exp(A_EXT, 16'hFFFF, "R6 smul ext negative");

        // R4, R6: unsigned accumulate with carry out of bit 31
        wr(A_UMUL, 16'h0000, "R2 op1 umul zero");
        wr(A_OP2,  16'h0000, "R3 clear acc");
        wr(A_UMAC, 16'hFFFF, "R2 op1 umac");
        wr(A_OP2,  16'hFFFF, "R4 umac first");
        rd_exp(A_EXT, 16'h0000, "R6 umac no carry");
        wr(A_OP2,  16'hFFFF, "R4 umac second");
        rd_exp(A_RLO, 16'h0002, "R4 umac wrapped low");
        rd_exp(A_RHI, 16'hFFFC, "R4 umac wrapped high");
        rd_exp(A_EXT, 16'h0001, "R6 umac carry");

        // R7, R4, R6: signed preset then signed accumulate back to zero
        wr(A_SMAC, 16'h0002, "R2 op1 smac");
        wr(A_RLO,  16'h8000, "R7 signed preset");
        rd_exp(A_RHI, 16'hFFFF, "R7 sign-extended high");
        rd_exp(A_EXT, 16'hFFFF, "R6 smac ext negative");
        wr(A_OP2,  16'h4000, "R4 smac add");
        rd_exp(A_RLO, 16'h0000, "R4 smac low");
        rd_exp(A_EXT, 16'h0000, "R6 smac ext non-negative");

        // R9: read and preset of the low word in the same cycle
        cyc(A_RLO, 1'b1, 16'h1234, 1'b1, "R9 same-cycle");
        check(last_rd, 16'h0000, "R9 same-cycle old value");
        rd_exp(A_RLO, 16'h1234, "R9 low after preset");

        // R9: read right after operand-2 write
        wr(A_UMUL, 16'h0003, "R2 op1 umul 3");
        wr(A_OP2,  16'h0005, "R9 op2 write");
        rd_exp(A_RLO, 16'h000F, "R9 next-cycle result");

        // R8: writes with no effect
        wr(A_RHI, 16'hAAAA, "R8 write high");
        wr(A_EXT, 16'h5555, "R8 write ext");
        wr(16'h140, 16'h1111, "R8 write above window");
        wr(16'h12E, 16'h2222, "R8 write below window");
        rd_exp(A_RLO, 16'h000F, "R8 low unchanged");
        rd_exp(A_RHI, 16'h0000, "R8 high unchanged");
        wr(A_OP2, 16'h0002, "R8 op1 and mode kept");
        rd_exp(A_RLO, 16'h0006, "R8 op1 and mode unchanged");

        // R7: unsigned preset zero-extends
        wr(A_RLO, 16'h8000, "R7 unsigned preset");
        rd_exp(A_RHI, 16'h0000, "R7 zero-extended high");

        // R5: idle read and non-result addresses
        cyc(A_RLO, 1'b0, 16'h0, 1'b0, "R5 read enable low");
        check(last_rd, 16'h0000, "R5 read enable low zero");
        rd_exp(A_UMUL, 16'h0000, "R5 operand slot reads zero");
        rd_exp(A_OP2,  16'h0000, "R5 op2 slot reads zero");

        // Random mix over all slots and neighbours, model compared every cycle (R2..R9)
        for (int i = 0; i < 3000; i++) begin
            ra = 16'h12E + 16'(2 * ($urandom % 10));
            rd = 16'($urandom);
            rw = ($urandom % 3) != 0;
            rr = ($urandom % 2) != 0;
            cyc(ra, rw, rd, rr, "R4 R6 random mix");
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule